// File: doc/BRIEF.md
# Rotating Priority Interrupt Resolver

This block is the arbitration core of one eight-input interrupt controller. It watches eight request lines and latches a pending bit on each rising edge. It screens the pending set through a mask and ranks what remains against a programmable rotation offset. The best candidate is then compared with the best line already in service. A request goes to the processor only when the candidate strictly outranks everything in service, and it is reported together with its 3-bit line number.

When the processor acknowledges, the reported line leaves the pending set and normally enters the in-service set. In automatic end-of-interrupt mode the in-service set is left alone, and rotation may also be enabled: the acknowledged line then becomes the lowest priority. A separate programming port writes the mask, the rotation offset and three mode flags. One mode flag is meant for a master in a cascaded pair. It leaves the cascade line out of the in-service comparison, so that a second request can come through that line while the first is still in service.

Top module: `rot_prio_resolver`

## Requirements
- R1: Each line keeps its own sampled previous level. A pending bit is set only when its input is high now and was low at the previous clock edge. A level held high sets the bit only once.
- R2: Only pending bits whose mask bit (`mask_val` bit n for line n, 1 = masked) is clear can be selected. A masked request stays pending and is selected once it is unmasked.
- R3: The rank of line n is (n - rotation) mod 8, where 0 is the best rank. The selected line is the candidate with the lowest rank, and `int_idx` carries its line number.
- R4: `int_req` is raised only when the best candidate's rank is strictly lower than the best in-service rank. A candidate ranked equal to or below an in-service line raises nothing.
- R5: While the cascade-exclusion flag is set, the in-service bit of line `CASCADE_LINE` (default 2) is ignored in the in-service comparison.
- R6: An acknowledge that arrives while `int_req` is high clears the pending bit of line `int_idx`. If automatic end of interrupt is off, it also sets that line's in-service bit. An acknowledge that arrives while `int_req` is low changes nothing. A rising edge in the same cycle sets the pending bit again.
- R7: With automatic end of interrupt on, an acknowledge leaves the in-service register unchanged.
- R8: With automatic end of interrupt and rotate-on-acknowledge both on, an acknowledge sets the rotation offset to (`int_idx` + 1) mod 8.
- R9: `int_req` and `int_idx` are registered and follow the register contents one cycle later. `int_idx` is 0 while `int_req` is low. A synchronous reset clears the pending, in-service, mask, previous-level and rotation registers and every mode flag.
- R10: `rot_wr` loads `rot_val` into the rotation offset. `mode_wr` loads the three mode flags. A rotation write overrides the rotation caused by an acknowledge in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | 8 | Raw request lines, bit n is line n |
| ack | input | 1 | Processor acknowledge of the reported line |
| mask_wr | input | 1 | Load strobe for the mask |
| mask_val | input | 8 | New mask, 1 blocks the line |
| rot_wr | input | 1 | Load strobe for the rotation offset |
| rot_val | input | 3 | New rotation offset (line holding rank 0) |
| mode_wr | input | 1 | Load strobe for the mode flags |
| mode_aeoi | input | 1 | Automatic end of interrupt |
| mode_rot_aeoi | input | 1 | Rotate on acknowledge in automatic mode |
| mode_sfn | input | 1 | Exclude the cascade line from the in-service comparison |
| int_req | output | 1 | Interrupt request to the processor |
| int_idx | output | 3 | Line number of the reported request |
| irr_out | output | 8 | Pending register contents |
| isr_out | output | 8 | In-service register contents |

## Verification
The hardest case to reach is a request that outranks a line already in service. It needs a completed acknowledge to fill the in-service register, then a fresh falling and rising edge on a better line, and no end-of-interrupt path exists to undo the first step. Directed sequences build this up line by line, including the cascade line being requested again while it is in service. Random phases toggle lines sparsely, so that edges stay distinct, and they interleave acknowledges, rotation writes and mode writes, with occasional resets to empty the in-service register again. A cycle-level reference model in the bench checks every output on every cycle.

// File: rtl/rpr_pkg.sv
package rpr_pkg;
    localparam int LINES = 8;
    localparam int IDXW  = $clog2(LINES);
    localparam int RANKW = IDXW + 1;

    typedef logic [LINES-1:0] line_vec_t;
    typedef logic [IDXW-1:0]  line_idx_t;
    typedef logic [RANKW-1:0] rank_t;

    typedef struct packed {
        logic aeoi;
        logic rot_on_aeoi;
        logic sfn;
    } mode_t;

    function automatic line_vec_t line_onehot(input line_idx_t n);
        return line_vec_t'(1) << n;
    endfunction
endpackage

// File: rtl/rpr_edge_capture.sv
module rpr_edge_capture
    import rpr_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  line_vec_t lvl,
    output line_vec_t rise
);
    line_vec_t prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '0;
        else     prev_q <= lvl;
    end

    assign rise = lvl & ~prev_q;
endmodule

// File: rtl/rpr_rank_scan.sv
module rpr_rank_scan
    import rpr_pkg::*;
(
    input  line_vec_t bits,
    input  line_idx_t rot,
    output rank_t     rank
);
    // lowest offset from rot whose bit is set; LINES when none
    always_comb begin
        rank = rank_t'(LINES);
        for (int k = LINES - 1; k >= 0; k--) begin
            if (bits[line_idx_t'(k) + rot]) rank = rank_t'(k);
        end
    end
endmodule

// File: rtl/rot_prio_resolver.sv
module rot_prio_resolver
    import rpr_pkg::*;
#(
    parameter int CASCADE_LINE = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [LINES-1:0] irq_in,
    input  logic             ack,
    input  logic             mask_wr,
    input  logic [LINES-1:0] mask_val,
    input  logic             rot_wr,
    input  logic [IDXW-1:0]  rot_val,
    input  logic             mode_wr,
    input  logic             mode_aeoi,
    input  logic             mode_rot_aeoi,
    input  logic             mode_sfn,
    output logic             int_req,
    output logic [IDXW-1:0]  int_idx,
    output logic [LINES-1:0] irr_out,
    output logic [LINES-1:0] isr_out
);
    line_vec_t irr_q, isr_q, mask_q;
    line_idx_t rot_q, idx_q;
    mode_t     mode_q;
    logic      req_q;

    line_vec_t rise, cand, serv_view, ack_bit;
    rank_t     pend_rank, serv_rank;
    logic      want, ack_take;
    line_idx_t pick_line;

    rpr_edge_capture u_edge (
        .clk  (clk),
        .rst  (rst),
        .lvl  (irq_in),
        .rise (rise)
    );

    always_comb begin
        cand      = irr_q & ~mask_q;
        serv_view = isr_q;
        if (mode_q.sfn) serv_view[CASCADE_LINE] = 1'b0;
    end

    rpr_rank_scan u_pend_scan (
        .bits (cand),
        .rot  (rot_q),
        .rank (pend_rank)
    );

    rpr_rank_scan u_serv_scan (
        .bits (serv_view),
        .rot  (rot_q),
        .rank (serv_rank)
    );

    assign want      = pend_rank < serv_rank;
    assign pick_line = pend_rank[IDXW-1:0] + rot_q;
    assign ack_take  = ack & req_q;
    assign ack_bit   = ack_take ? line_onehot(idx_q) : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            irr_q  <= '0;
            isr_q  <= '0;
            mask_q <= '0;
            rot_q  <= '0;
            mode_q <= '0;
            req_q  <= 1'b0;
            idx_q  <= '0;
        end else begin
            irr_q <= (irr_q & ~ack_bit) | rise;
            if (ack_take && !mode_q.aeoi) isr_q <= isr_q | ack_bit;
            if (mask_wr) mask_q <= mask_val;
            if (rot_wr)
                rot_q <= rot_val;
            else if (ack_take && mode_q.aeoi && mode_q.rot_on_aeoi)
                rot_q <= idx_q + line_idx_t'(1);
            if (mode_wr) begin
                mode_q.aeoi        <= mode_aeoi;
                mode_q.rot_on_aeoi <= mode_rot_aeoi;
                mode_q.sfn         <= mode_sfn;
            end
            req_q <= want;
            idx_q <= want ? pick_line : '0;
        end
    end

    assign int_req = req_q;
    assign int_idx = idx_q;
    assign irr_out = irr_q;
    assign isr_out = isr_q;
endmodule

// File: rtl/rpr_checker.sv
module rpr_checker
    import rpr_pkg::*;
#(
    parameter int CASCADE_LINE = 2
) (
    input logic      clk,
    input logic      rst,
    input line_vec_t irq_in,
    input logic      ack,
    input logic      rot_wr,
    input logic      int_req,
    input line_idx_t int_idx,
    input line_vec_t irr_out,
    input line_vec_t isr_out,
    input line_vec_t mask_q,
    input line_idx_t rot_q,
    input mode_t     mode_q
);
    assert_edge_only_R1: assert property (@(posedge clk) disable iff (rst)
        (irr_out & ~$past(irr_out) & ~$past(irq_in)) == '0);

    assert_unmasked_R2: assert property (@(posedge clk) disable iff (rst)
        int_req |-> ((($past(irr_out & ~mask_q) >> int_idx) & line_vec_t'(1)) != '0));

    // R5: the cascade line may be reported while in service under exclusion
    assert_not_in_service_R4: assert property (@(posedge clk) disable iff (rst)
        int_req |-> (((($past(isr_out) >> int_idx) & line_vec_t'(1)) == '0)
                     || (int_idx == line_idx_t'(CASCADE_LINE) && $past(mode_q.sfn))));

    assert_ack_service_R6: assert property (@(posedge clk) disable iff (rst)
        (ack && int_req && !mode_q.aeoi) |=>
            (((isr_out >> $past(int_idx)) & line_vec_t'(1)) != '0));

    assert_aeoi_keep_R7: assert property (@(posedge clk) disable iff (rst)
        (ack && int_req && mode_q.aeoi) |=> (isr_out == $past(isr_out)));

    assert_rotate_R8: assert property (@(posedge clk) disable iff (rst)
        (ack && int_req && mode_q.aeoi && mode_q.rot_on_aeoi && !rot_wr) |=>
            (rot_q == line_idx_t'($past(int_idx) + line_idx_t'(1))));

    assert_idle_idx_R9: assert property (@(posedge clk) disable iff (rst)
        !int_req |-> (int_idx == '0));
endmodule

bind rot_prio_resolver rpr_checker #(.CASCADE_LINE(CASCADE_LINE)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .irq_in  (irq_in),
    .ack     (ack),
    .rot_wr  (rot_wr),
    .int_req (int_req),
    .int_idx (int_idx),
    .irr_out (irr_out),
    .isr_out (isr_out),
    .mask_q  (mask_q),
    .rot_q   (rot_q),
    .mode_q  (mode_q)
);

// File: tb/rot_prio_resolver_test.sv
module rot_prio_resolver_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] irq_in = '0;
    logic       ack = 1'b0;
    logic       mask_wr = 1'b0;
    logic [7:0] mask_val = '0;
    logic       rot_wr = 1'b0;
    logic [2:0] rot_val = '0;
    logic       mode_wr = 1'b0;
    logic       mode_aeoi = 1'b0, mode_rot_aeoi = 1'b0, mode_sfn = 1'b0;
    logic       int_req;
    logic [2:0] int_idx;
    logic [7:0] irr_out, isr_out;

    int checks = 0;
    int failures = 0;

    // reference state
    logic [7:0] m_irr = '0, m_isr = '0, m_mask = '0, m_last = '0;
    logic [2:0] m_rot = '0, m_idx = '0;
    logic       m_req = 1'b0, m_aeoi = 1'b0, m_raeoi = 1'b0, m_sfn = 1'b0;

    always #10 clk = ~clk;

    rot_prio_resolver uut (
        .clk(clk), .rst(rst), .irq_in(irq_in), .ack(ack),
        .mask_wr(mask_wr), .mask_val(mask_val), .rot_wr(rot_wr), .rot_val(rot_val),
        .mode_wr(mode_wr), .mode_aeoi(mode_aeoi), .mode_rot_aeoi(mode_rot_aeoi),
        .mode_sfn(mode_sfn), .int_req(int_req), .int_idx(int_idx),
        .irr_out(irr_out), .isr_out(isr_out)
    );

    function automatic int rank_of(logic [7:0] v, logic [2:0] r);
        for (int off = 0; off < 8; off++)
            if (v[(off + int'(r)) % 8]) return off;
        return 8;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_irr = '0; m_isr = '0; m_mask = '0; m_last = '0; m_rot = '0;
            m_req = 0; m_idx = '0; m_aeoi = 0; m_raeoi = 0; m_sfn = 0;
        end else begin
            logic [7:0] sv;
            int pr, sr;
            logic       nreq;
            logic [2:0] nidx;
            sv = m_isr;
            if (m_sfn) sv[2] = 1'b0;
            pr = rank_of(m_irr & ~m_mask, m_rot);
            sr = rank_of(sv, m_rot);
            nreq = pr < sr;
            nidx = nreq ? 3'((pr + int'(m_rot)) % 8) : 3'd0;
            if (ack && m_req) begin
                m_irr[m_idx] = 1'b0;
                if (!m_aeoi) m_isr[m_idx] = 1'b1;
                if (m_aeoi && m_raeoi) m_rot = m_idx + 3'd1;
            end
            m_irr = m_irr | (irq_in & ~m_last);
            m_last = irq_in;
            if (mask_wr) m_mask = mask_val;
            if (rot_wr) m_rot = rot_val;
            if (mode_wr) begin
                m_aeoi = mode_aeoi; m_raeoi = mode_rot_aeoi; m_sfn = mode_sfn;
            end
            m_req = nreq;
            m_idx = nidx;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            chk("R1 pending", irr_out, m_irr);
            chk("R6 in-service", isr_out, m_isr);
            chk("R4 int_req", int_req, m_req);
            chk("R3 int_idx", int_idx, m_idx);
        end
    endtask

    task automatic do_reset();
        rst = 1; irq_in = '0; ack = 0; mask_wr = 0; rot_wr = 0; mode_wr = 0;
        tick(2);
        rst = 0;
    endtask

    task automatic pulse_ack();
        ack = 1; tick(1); ack = 0;
    endtask

    task automatic set_mode(input logic a, input logic r, input logic s);
        mode_wr = 1; mode_aeoi = a; mode_rot_aeoi = r; mode_sfn = s;
        tick(1); mode_wr = 0;
    endtask

    initial begin
        #4_000_000;
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'd5171));
        do_reset();
        tick(1);
        chk("R9 reset irr", irr_out, 0);
        chk("R9 reset req", int_req, 0);

        // R1 single edge on line 5, held high
        irq_in = 8'h20; tick(3);
        chk("R1 edge sets", irr_out, 8'h20);
        chk("R3 idx line5", int_idx, 5);
        pulse_ack(); tick(2);
        chk("R1 held level no reset", irr_out, 8'h00);
        chk("R6 ack into service", isr_out, 8'h20);
        ack = 1; tick(2); ack = 0;
        chk("R6 ack ignored when idle", isr_out, 8'h20);

        // R2 masking
        do_reset();
        mask_wr = 1; mask_val = 8'h08; tick(1); mask_wr = 0;
        irq_in = 8'h08; tick(3);
        chk("R2 masked pending", irr_out, 8'h08);
        chk("R2 masked no req", int_req, 0);
        mask_wr = 1; mask_val = 8'h00; tick(1); mask_wr = 0; tick(2);
        chk("R2 unmasked req", int_req, 1);
        chk("R2 unmasked idx", int_idx, 3);

        // R3 rotation ranking
        do_reset();
        rot_wr = 1; rot_val = 3'd5; tick(1); rot_wr = 0;
        irq_in = 8'h42; tick(3);
        chk("R3 rot5 picks 6", int_idx, 6);
        rot_wr = 1; rot_val = 3'd7; tick(1); rot_wr = 0; tick(2);
        chk("R3 rot7 picks 1", int_idx, 1);

        // R4 strict comparison against in-service
        do_reset();
        irq_in = 8'h10; tick(3); pulse_ack(); tick(2);
        irq_in = 8'h50; tick(3);
        chk("R4 lower rank blocked", int_req, 0);
        irq_in = 8'h52; tick(3);
        chk("R4 higher rank req", int_req, 1);
        chk("R4 higher rank idx", int_idx, 1);

        // R5 cascade exclusion
        do_reset();
        set_mode(0, 0, 1);
        irq_in = 8'h04; tick(3); pulse_ack(); tick(2);
        irq_in = 8'h00; tick(1); irq_in = 8'h04; tick(3);
        chk("R5 cascade re-request", int_req, 1);
        chk("R5 cascade idx", int_idx, 2);
        set_mode(0, 0, 0); tick(2);
        chk("R5 exclusion off blocks", int_req, 0);

        // R7 / R8 automatic end of interrupt with rotation
        do_reset();
        set_mode(1, 1, 0);
        irq_in = 8'h08; tick(3); pulse_ack(); tick(2);
        chk("R7 aeoi keeps in-service", isr_out, 8'h00);
        irq_in = 8'h2C; tick(3);
        chk("R8 rotated pick", int_idx, 5);
        // R10 rotation write beats acknowledge rotation
        irq_in = 8'hAC; tick(3);
        ack = 1; rot_wr = 1; rot_val = 3'd0; tick(1); ack = 0; rot_wr = 0; tick(2);
        chk("R10 write wins", int_idx, 2);

        // random phase
        do_reset();
        for (int c = 0; c < 4000; c++) begin
            irq_in  = irq_in ^ (8'($urandom) & 8'($urandom) & 8'($urandom));
            ack     = ($urandom % 3) == 0;
            mask_wr = ($urandom % 16) == 0;
            mask_val = 8'($urandom) & 8'($urandom);
            rot_wr  = ($urandom % 20) == 0;
            rot_val = 3'($urandom);
            mode_wr = ($urandom % 24) == 0;
            mode_aeoi = 1'($urandom); mode_rot_aeoi = 1'($urandom); mode_sfn = 1'($urandom);
            rst     = ($urandom % 150) == 0;
            tick(1);
        end
        rst = 0; ack = 0; mask_wr = 0; rot_wr = 0; mode_wr = 0;
        tick(2);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule